// File: doc/BRIEF.md
# Full/Empty Synchronizing Memory Bank

This block is a word-addressed storage bank where each word has a one-bit presence flag next to its data. The flag lets threads hand values to each other through memory without locks. A consumer's synchronized load waits until a producer has filled the word, then takes the value and marks the word empty. A producer's synchronized store waits until the word is empty, then writes it and marks it full. The bank also has plain loads and stores that ignore the flag, two operations that set the flag directly, and a fetch-and-add that reads, adds and writes back as one indivisible bank operation.

Requests enter on a valid/ready port with an operation code, a word address, a data operand and a requester tag. A synchronized request whose flag condition does not hold yet is parked in a small in-order retry queue. It completes later, after another request has changed the flag. Every response returns the requester tag, so responses can come back in a different order from the requests. The response port is also valid/ready. A pending response is held until it is taken, and the bank does no work while a response is waiting. The bank performs at most one memory operation per cycle.

Top module: `fe_sync_bank`

## Requirements
- R1: After reset every word holds data 0 with its flag clear (empty), `rsp_valid` is low and `req_ready` is high.
- R2: Op code 0 (plain load) returns the word and leaves it unchanged. Op code 1 (plain store) writes the operand and leaves the flag as it was. Every response carries the word's data and flag as they were just before the operation, on `rsp_data` and `rsp_full`.
- R3: Op code 2 (synchronized load) on a full word completes and clears the flag. On an empty word it produces no response and is parked.
- R4: Op code 3 (synchronized store) on an empty word writes the operand and sets the flag. On a full word it produces no response and is parked.
- R5: Op code 4 (fetch-and-add) returns the old data and stores old plus operand, modulo 2^DW. It leaves the flag unchanged and completes as one request.
- R6: Op code 5 (fill) writes the operand and sets the flag. Op code 6 (drain) clears the flag and keeps the data. Op code 7 behaves as a plain load.
- R7: Parked requests are retried only from the head of the queue, in arrival order. A head whose condition holds completes before any new request. A head that is still blocked holds back every entry behind it, even when a later entry could complete.
- R8: While the retry queue holds QD entries, a request that would have to park sees `req_ready` low. A request that can complete at once is still accepted.
- R9: Each response returns the tag of the request it answers. A request that completes at once may be answered before an earlier parked request.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response stays unchanged and no request is accepted.
- R11: A request that completes in the cycle it is accepted, or a queue head that completes, raises `rsp_valid` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank takes the request at this edge |
| req_op | input | 3 | Operation code (see R2 to R6) |
| req_addr | input | AW | Word address |
| req_data | input | DW | Store value or addend |
| req_tag | input | TW | Requester tag, echoed back |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DW | Word data before the operation |
| rsp_full | output | 1 | Word flag before the operation |
| rsp_tag | output | TW | Tag of the answered request |

## Verification
The assertions assume that the consumer drains responses often enough for a held response to be released eventually. They also assume that a requester whose request is refused for lack of queue space either waits or withdraws the request. The bench only ever withdraws such a request after it has observed the refusal. The queue-overflow check assumes that a parked request arrives only through the ready handshake. The bench keeps every parked consumer matched by a later producer to the same word, so the queue always drains before the run ends.

// File: rtl/fe_pkg.sv
package fe_pkg;

  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_SLOAD  = 3'd2,
    OP_SSTORE = 3'd3,
    OP_FADD   = 3'd4,
    OP_FILL   = 3'd5,
    OP_DRAIN  = 3'd6,
    OP_RSVD   = 3'd7
  } fe_op_e;

  localparam int OP_W = 3;

endpackage

// File: rtl/fe_word_array.sv
module fe_word_array #(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int NRD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr [NRD],
  output logic [DW-1:0] rd_data [NRD],
  output logic          rd_full [NRD],
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_full
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    words [DEPTH];
  logic [DEPTH-1:0] flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
      flags <= '0;
    end else if (wr_en) begin
      words[wr_addr] <= wr_data;
      flags[wr_addr] <= wr_full;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = words[rd_addr[p]];
    assign rd_full[p] = flags[rd_addr[p]];
  end

endmodule

// File: rtl/fe_op_eval.sv
module fe_op_eval
  import fe_pkg::*;
#(
  parameter int DW = 32
) (
  input  fe_op_e        op,
  input  logic [DW-1:0] old_data,
  input  logic          old_full,
  input  logic [DW-1:0] operand,
  output logic          blocked,
  output logic          wr_en,
  output logic [DW-1:0] new_data,
  output logic          new_full
);

  always_comb begin
    blocked  = 1'b0;
    wr_en    = 1'b0;
    new_data = old_data;
    new_full = old_full;
    unique case (op)
      OP_STORE: begin
        wr_en    = 1'b1;
        new_data = operand;
      end
      OP_SLOAD: begin
        blocked  = !old_full;
        wr_en    = old_full;
        new_full = 1'b0;
      end
      OP_SSTORE: begin
        blocked  = old_full;
        wr_en    = !old_full;
        new_data = operand;
        new_full = 1'b1;
      end
      OP_FADD: begin
        wr_en    = 1'b1;
        new_data = old_data + operand;
      end
      OP_FILL: begin
        wr_en    = 1'b1;
        new_data = operand;
        new_full = 1'b1;
      end
      OP_DRAIN: begin
        wr_en    = 1'b1;
        new_full = 1'b0;
      end
      default: begin
        wr_en = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/fe_retry_fifo.sv
module fe_retry_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_data;
  end

  assign head  = slots[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push || pop);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);

endmodule

// File: rtl/fe_sync_bank.sv
module fe_sync_bank
  import fe_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int TW = 8,
  parameter int QD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [TW-1:0] req_tag,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_full,
  output logic [TW-1:0] rsp_tag
);

  localparam int EW = OP_W + AW + DW + TW;

  // retry queue
  logic [EW-1:0] q_head;
  logic          q_empty, q_full, q_push, q_pop;

  fe_op_e        h_op;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_data;
  logic [TW-1:0] h_tag;

  assign h_op   = fe_op_e'(q_head[EW-1 -: OP_W]);
  assign h_addr = q_head[DW+TW +: AW];
  assign h_data = q_head[TW +: DW];
  assign h_tag  = q_head[TW-1:0];

  // storage, port 0 serves the queue head, port 1 the new request
  logic [AW-1:0] rd_addr [2];
  logic [DW-1:0] rd_data [2];
  logic          rd_full [2];
  logic          wr_en, wr_full;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  assign rd_addr[0] = h_addr;
  assign rd_addr[1] = req_addr;

  fe_word_array #(.AW(AW), .DW(DW), .NRD(2)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .rd_full (rd_full),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_full (wr_full)
  );

  logic          h_blocked, h_wr, h_nfull;
  logic [DW-1:0] h_ndata;
  logic          n_blocked, n_wr, n_nfull;
  logic [DW-1:0] n_ndata;

  fe_op_eval #(.DW(DW)) u_head_eval (
    .op       (h_op),
    .old_data (rd_data[0]),
    .old_full (rd_full[0]),
    .operand  (h_data),
    .blocked  (h_blocked),
    .wr_en    (h_wr),
    .new_data (h_ndata),
    .new_full (h_nfull)
  );

  fe_op_eval #(.DW(DW)) u_new_eval (
    .op       (fe_op_e'(req_op)),
    .old_data (rd_data[1]),
    .old_full (rd_full[1]),
    .operand  (req_data),
    .blocked  (n_blocked),
    .wr_en    (n_wr),
    .new_data (n_ndata),
    .new_full (n_nfull)
  );

  // scheduling: one memory operation per cycle, ready head first
  logic advance, head_ok, head_go, new_fire, new_done, done;

  assign advance   = !rsp_valid || rsp_ready;
  assign head_ok   = !q_empty && !h_blocked;
  assign head_go   = head_ok && advance;
  assign req_ready = advance && !head_ok && (!q_full || !n_blocked);
  assign new_fire  = req_valid && req_ready;
  assign new_done  = new_fire && !n_blocked;
  assign done      = head_go || new_done;

  assign q_push = new_fire && n_blocked;
  assign q_pop  = head_go;

  fe_retry_fifo #(.W(EW), .DEPTH(QD)) u_retry (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data ({req_op, req_addr, req_data, req_tag}),
    .pop       (q_pop),
    .head      (q_head),
    .empty     (q_empty),
    .full      (q_full)
  );

  assign wr_en   = head_go ? h_wr    : (new_done && n_wr);
  assign wr_addr = head_go ? h_addr  : req_addr;
  assign wr_data = head_go ? h_ndata : n_ndata;
  assign wr_full = head_go ? h_nfull : n_nfull;

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_full  <= 1'b0;
      rsp_tag   <= '0;
    end else if (done) begin
      rsp_valid <= 1'b1;
      rsp_data  <= head_go ? rd_data[0] : rd_data[1];
      rsp_full  <= head_go ? rd_full[0] : rd_full[1];
      rsp_tag   <= head_go ? h_tag : req_tag;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) &&
                                $stable(rsp_tag) && $stable(rsp_full));

  // R10
  stall_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !(req_valid && req_ready));

  // R11
  done_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rsp_valid);

endmodule

// File: tb/sim_fe_sync_bank.sv
module sim_fe_sync_bank;

  localparam int AW = 4;
  localparam int DW = 32;
  localparam int TW = 8;
  localparam int QD = 4;
  localparam int NV = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, rsp_valid, rsp_ready, rsp_full;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data, rsp_data;
  logic [TW-1:0] req_tag, rsp_tag;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fe_sync_bank #(.AW(AW), .DW(DW), .TW(TW), .QD(QD)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_full(rsp_full), .rsp_tag(rsp_tag)
  );

  // {op, addr, operand, expected old data, expected old flag}, from reset state
  localparam logic [71:0] VEC [NV] = '{
    {3'd0, 4'd9, 32'h0,        32'h0,  1'b0},
    {3'd1, 4'd3, 32'h11,       32'h0,  1'b0},
    {3'd0, 4'd3, 32'h0,        32'h11, 1'b0},
    {3'd5, 4'd3, 32'h22,       32'h11, 1'b0},
    {3'd0, 4'd3, 32'h0,        32'h22, 1'b1},
    {3'd1, 4'd3, 32'h33,       32'h22, 1'b1},
    {3'd0, 4'd3, 32'h0,        32'h33, 1'b1},
    {3'd2, 4'd3, 32'h0,        32'h33, 1'b1},
    {3'd0, 4'd3, 32'h0,        32'h33, 1'b0},
    {3'd3, 4'd3, 32'h44,       32'h33, 1'b0},
    {3'd0, 4'd3, 32'h0,        32'h44, 1'b1},
    {3'd4, 4'd5, 32'h7,        32'h0,  1'b0},
    {3'd4, 4'd5, 32'h5,        32'h7,  1'b0},
    {3'd0, 4'd5, 32'h0,        32'hC,  1'b0},
    {3'd4, 4'd5, 32'hFFFFFFFF, 32'hC,  1'b0},
    {3'd0, 4'd5, 32'h0,        32'hB,  1'b0},
    {3'd6, 4'd3, 32'h0,        32'h44, 1'b1},
    {3'd7, 4'd3, 32'h0,        32'h44, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [TW-1:0] t);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_tag = t;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input logic [DW-1:0] d, input logic f,
                            input logic [TW-1:0] t, input string req);
    @(negedge clk);
    chk(rsp_valid === 1'b1, {req, " rsp_valid"}, longint'(rsp_valid), 1);
    chk(rsp_tag === t, {req, " rsp_tag"}, longint'(rsp_tag), longint'(t));
    chk(rsp_data === d, {req, " rsp_data"}, longint'(rsp_data), longint'(d));
    chk(rsp_full === f, {req, " rsp_full"}, longint'(rsp_full), longint'(f));
  endtask

  task automatic expect_none(input string req);
    @(negedge clk);
    chk(rsp_valid === 1'b0, {req, " no response"}, longint'(rsp_valid), 0);
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R2";
      3'd2:       return "R3";
      3'd3:       return "R4";
      3'd4:       return "R5";
      default:    return "R6";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0;
    req_data = '0; req_tag = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", longint'(rsp_valid), 0);
    chk(req_ready === 1'b1, "R1 req_ready after reset", longint'(req_ready), 1);

    // table walk: R11 one-cycle latency on every row
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][71:69], VEC[i][68:65], VEC[i][64:33], TW'(i));
      expect_rsp(VEC[i][32:1], VEC[i][0], TW'(i), req_of(VEC[i][71:69]));
    end

    // R3 parked consumers, R9 out-of-order reply, R7 head-of-line order
    send(3'd2, 4'd7, 32'h0, 8'd20);
    expect_none("R3 sync load on empty parks");
    send(3'd2, 4'd8, 32'h0, 8'd21);
    expect_none("R3 second parked load");
    send(3'd3, 4'd8, 32'h88, 8'd22);
    expect_rsp(32'h0, 1'b0, 8'd22, "R9 later request answered first");
    expect_none("R7 blocked head holds entry behind it");
    send(3'd3, 4'd7, 32'h77, 8'd23);
    expect_rsp(32'h0, 1'b0, 8'd23, "R4 producer fills word");
    expect_rsp(32'h77, 1'b1, 8'd20, "R7 head completes first");
    expect_rsp(32'h88, 1'b1, 8'd21, "R7 next entry follows");
    send(3'd0, 4'd7, 32'h0, 8'd24);
    expect_rsp(32'h77, 1'b0, 8'd24, "R3 retried load emptied word");

    // R8 full queue refuses parking requests only
    for (int k = 0; k < QD; k++) begin
      send(3'd2, 4'd10, 32'h0, TW'(30 + k));
      expect_none("R3 fill queue");
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd2; req_addr = 4'd11; req_tag = 8'd34;
    #1;
    chk(req_ready === 1'b0, "R8 parking request refused when queue full", longint'(req_ready), 0);
    @(negedge clk);
    #1;
    chk(req_ready === 1'b0, "R8 still refused", longint'(req_ready), 0);
    req_valid = 1'b0;
    for (int k = 0; k < QD; k++) begin
      send(3'd3, 4'd10, DW'(32'hA0 + k), TW'(35 + k));
      expect_rsp(k == 0 ? 32'h0 : DW'(32'hA0 + k - 1), 1'b0, TW'(35 + k),
                 "R8 completing request accepted with full queue");
      expect_rsp(DW'(32'hA0 + k), 1'b1, TW'(30 + k), "R7 queued load in arrival order");
    end
    #1;
    chk(req_ready === 1'b1, "R8 ready after queue drained", longint'(req_ready), 1);

    // R10 response held while consumer stalls
    @(negedge clk);
    rsp_ready = 1'b0;
    send(3'd0, 4'd3, 32'h0, 8'd40);
    expect_rsp(32'h44, 1'b0, 8'd40, "R10 first response");
    req_valid = 1'b1; req_op = 3'd0; req_addr = 4'd5; req_tag = 8'd41;
    #1;
    chk(req_ready === 1'b0, "R10 no accept while response held", longint'(req_ready), 0);
    @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_tag === 8'd40, "R10 response held tag",
        longint'(rsp_tag), 40);
    chk(rsp_data === 32'h44, "R10 response held data", longint'(rsp_data), 32'h44);
    rsp_ready = 1'b1;
    #1;
    chk(req_ready === 1'b1, "R10 ready once consumer takes", longint'(req_ready), 1);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    expect_rsp(32'hB, 1'b0, 8'd41, "R10 next response after release");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule